// File: doc/BRIEF.md
# Supply Recharge Activity Monitor

This block watches a supply rail that a separate controller tops up at intervals during standby. Each time the controller begins a recharge it pulses a start input. In the same cycle a comparator flag tells whether the rail was still above its OK threshold. The monitor pushes that flag into a short shift history. It also counts slow-clock periods between recharge starts. From these counts it keeps the longest gap after which the rail was still healthy. Software can read that figure as a measure of standby leakage, and clear it.

A two-entry register interface carries the recharge mode selection and the status. The mode codes are 0 = off, 1 = fixed-interval timer, 2 = self-tuning timer and 3 = external comparator. While the mode is off, the monitor ignores recharge starts. Any write to the status entry clears the longest-gap figure. The slow clock arrives as a one-cycle enable pulse in the system clock domain.

Top module: `rchg_monitor`

## Requirements
- R1: After reset, the mode reads 0, the sample history reads 0 and the longest-gap field reads 0.
- R2: A write to address 0 stores `wr_data[1:0]` as the mode. Reading address 0 returns the mode in bits [1:0] and zeros above.
- R3: On each accepted recharge start, the 4-bit history shifts one place toward its MSB, and bit 0 takes `rail_ok` (1 = above threshold). The history reads at bits [19:16] of address 1.
- R4: While the mode is 0, recharge starts are ignored: neither the history nor the longest-gap field changes.
- R5: The gap is the number of cycles with `lf_tick` high strictly between two accepted starts. On an accepted start with `rail_ok` = 1, the longest-gap field, at bits [15:0] of address 1, takes the gap if the gap is larger than the stored value.
- R6: An accepted start with `rail_ok` = 0 never changes the longest-gap field.
- R7: The first accepted start after reset never changes the longest-gap field.
- R8: The gap count saturates at 0xFFFF and does not wrap.
- R9: A write to address 1, whatever the data, clears the longest-gap field to 0 and leaves the history unchanged.
- R10: When a status write and a qualifying start fall in the same cycle, the field reads 0 afterwards.
- R11: A gap that is not larger than the stored value leaves the longest-gap field unchanged.
- R12: A `lf_tick` pulse in the same cycle as an accepted start is not counted in the gap that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | One-cycle pulse per slow-clock period |
| rchg_start | input | 1 | One-cycle pulse when a recharge begins |
| rail_ok | input | 1 | Comparator flag: rail above the OK threshold |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = mode, 1 = status |
| wr_data | input | 2 | Write data; the mode code for address 0 |
| rd_addr | input | 1 | Read address: 0 = mode, 1 = status |
| rd_data | output | 32 | Combinational read data |

## Verification
A table drives a series of recharge starts with varied tick counts and comparator flags. Each step tells apart a growing gap, a shorter gap, a gap ended by an unhealthy sample and a zero-length gap, and the history shows whether each flag landed in the right bit. Directed cases then check that a start in off mode leaves everything unchanged. They also check a clear that lands together with a qualifying start, a tick that coincides with a start, the first start after reset, and a gap long enough to saturate the count.

// File: rtl/rchg_pkg.sv
package rchg_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_TUNED  = 2'd2,
    MODE_COMPAR = 2'd3
  } rchg_mode_e;

  // Register addresses
  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Push a new sample into the LSB of a 4-bit history
  function automatic logic [3:0] hist_push(input logic [3:0] h, input logic s);
    return {h[2:0], s};
  endfunction

  // Saturating increment for a 16-bit count
  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  // Whether a candidate gap replaces the stored maximum
  function automatic logic gap_wins(input logic [15:0] cand, input logic [15:0] cur);
    return cand > cur;
  endfunction

endpackage

// File: rtl/rchg_cfg_regs.sv
module rchg_cfg_regs
  import rchg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [MODE_W-1:0] wr_data,
  output rchg_mode_e        mode,
  output logic              stat_clr
);

  rchg_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= MODE_OFF;
    else if (wr_en && (wr_addr == ADDR_CFG))
      mode_q <= rchg_mode_e'(wr_data);
  end

  assign mode     = mode_q;
  assign stat_clr = wr_en && (wr_addr == ADDR_STAT);

endmodule

// File: rtl/rchg_interval_ctr.sv
module rchg_interval_ctr #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_tick,
  input  logic             evt,
  output logic [GAP_W-1:0] count,
  output logic             seen
);

  localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

  logic [GAP_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (evt) begin
        cnt_q  <= '0;
        seen_q <= 1'b1;
      end else if (lf_tick && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count = cnt_q;
  assign seen  = seen_q;

endmodule

// File: rtl/rchg_stats.sv
module rchg_stats
  import rchg_pkg::*;
#(
  parameter int HIST_W = 4,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              rail_ok,
  input  logic              seen,
  input  logic [GAP_W-1:0]  count,
  input  logic              clr,
  output logic [HIST_W-1:0] hist,
  output logic [GAP_W-1:0]  max_gap,
  output logic              gap_take
);

  logic [HIST_W-1:0] hist_q;
  logic [GAP_W-1:0]  max_q;

  // A start qualifies when the rail held and a previous start exists
  assign gap_take = evt && rail_ok && seen && (count > max_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hist_q <= '0;
    else if (evt)
      hist_q <= {hist_q[HIST_W-2:0], rail_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      max_q <= '0;
    else if (clr)
      max_q <= '0;
    else if (gap_take)
      max_q <= count;
  end

  assign hist    = hist_q;
  assign max_gap = max_q;

endmodule

// File: rtl/rchg_monitor.sv
module rchg_monitor
  import rchg_pkg::*;
#(
  parameter int HIST_W = 4,
  parameter int GAP_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_tick,
  input  logic              rchg_start,
  input  logic              rail_ok,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int STAT_USED = HIST_W + GAP_W;

  rchg_mode_e        mode;
  logic              stat_clr;
  logic              evt_accept;
  logic [GAP_W-1:0]  gap_cnt;
  logic              start_seen;
  logic [HIST_W-1:0] hist;
  logic [GAP_W-1:0]  max_gap;
  logic              gap_take;

  rchg_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode     (mode),
    .stat_clr (stat_clr)
  );

  // A start counts only when recharge is enabled
  assign evt_accept = rchg_start && (mode != MODE_OFF);

  rchg_interval_ctr #(.GAP_W(GAP_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .lf_tick (lf_tick),
    .evt     (evt_accept),
    .count   (gap_cnt),
    .seen    (start_seen)
  );

  rchg_stats #(.HIST_W(HIST_W), .GAP_W(GAP_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_accept),
    .rail_ok  (rail_ok),
    .seen     (start_seen),
    .count    (gap_cnt),
    .clr      (stat_clr),
    .hist     (hist),
    .max_gap  (max_gap),
    .gap_take (gap_take)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CFG)
      rd_data[MODE_W-1:0] = mode;
    else
      rd_data[STAT_USED-1:0] = {hist, max_gap};
  end

endmodule

// File: rtl/rchg_monitor_chk.sv
module rchg_monitor_chk
  import rchg_pkg::*;
#(
  parameter int HIST_W = 4,
  parameter int GAP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rchg_start,
  input logic              rail_ok,
  input rchg_mode_e        mode,
  input logic              evt_accept,
  input logic              stat_clr,
  input logic              start_seen,
  input logic [GAP_W-1:0]  gap_cnt,
  input logic [HIST_W-1:0] hist,
  input logic [GAP_W-1:0]  max_gap
);

  localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

  a_r3_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> hist == {$past(hist[HIST_W-2:0]), $past(rail_ok)});

  a_r4_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rchg_start && mode == MODE_OFF && !stat_clr) |=> ($stable(hist) && $stable(max_gap)));

  a_r6_low_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !rail_ok && !stat_clr) |=> $stable(max_gap));

  a_r7_first_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !start_seen && !stat_clr) |=> $stable(max_gap));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt == CNT_MAX && !evt_accept) |=> gap_cnt == CNT_MAX);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> max_gap == '0);

  a_r11_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> max_gap >= $past(max_gap));

endmodule

bind rchg_monitor rchg_monitor_chk #(.HIST_W(HIST_W), .GAP_W(GAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rchg_start (rchg_start),
  .rail_ok    (rail_ok),
  .mode       (mode),
  .evt_accept (evt_accept),
  .stat_clr   (stat_clr),
  .start_seen (start_seen),
  .gap_cnt    (gap_cnt),
  .hist       (hist),
  .max_gap    (max_gap)
);

// File: tb/rchg_monitor_tb.sv
module rchg_monitor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_tick = 1'b0;
  logic        rchg_start = 1'b0;
  logic        rail_ok = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [1:0]  wr_data = 2'd0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rchg_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .rchg_start(rchg_start),
    .rail_ok(rail_ok), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Entry: {ticks[7:0], ok, exp_hist[3:0], exp_max[15:0]}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {8'd5,  1'b1, 4'b0001, 16'd0},
    {8'd7,  1'b1, 4'b0011, 16'd7},
    {8'd3,  1'b1, 4'b0111, 16'd7},
    {8'd12, 1'b0, 4'b1110, 16'd7},
    {8'd9,  1'b1, 4'b1101, 16'd9},
    {8'd0,  1'b0, 4'b1010, 16'd9},
    {8'd20, 1'b1, 4'b0101, 16'd20},
    {8'd2,  1'b1, 4'b1011, 16'd20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic read(input logic a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_tick = 1'b1;
      @(negedge clk); lf_tick = 1'b0;
    end
  endtask

  task automatic start(input logic ok, input logic tk, input logic clr);
    @(negedge clk);
    rchg_start = 1'b1; rail_ok = ok; lf_tick = tk;
    wr_en = clr; wr_addr = 1'b1; wr_data = 2'd0;
    @(negedge clk);
    rchg_start = 1'b0; rail_ok = 1'b0; lf_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    read(1'b0, v); check("R1 mode", v, 32'd0);
    read(1'b1, v); check("R1 status", v, 32'd0);

    // R2 mode write and readback
    wr(1'b0, 2'd3); read(1'b0, v); check("R2 mode=3", v, 32'd3);
    wr(1'b0, 2'd2); read(1'b0, v); check("R2 mode=2", v, 32'd2);
    wr(1'b0, 2'd1); read(1'b0, v); check("R2 mode=1", v, 32'd1);

    // R3 R5 R6 R11 table walk
    for (int k = 0; k < NV; k++) begin
      ticks(int'(VEC[k][28:21]));
      start(VEC[k][20], 1'b0, 1'b0);
      read(1'b1, v);
      check("R3/R5/R6/R11 table", v, {12'd0, VEC[k][19:16], VEC[k][15:0]});
    end

    // R4 off mode ignores starts
    wr(1'b0, 2'd0);
    ticks(50);
    start(1'b1, 1'b0, 1'b0);
    start(1'b0, 1'b0, 1'b0);
    read(1'b1, v); check("R4 off ignored", v, {12'd0, 4'b1011, 16'd20});

    // R9 clear keeps history
    wr(1'b0, 2'd1);
    start(1'b0, 1'b0, 1'b0);               // hist 0110
    wr(1'b1, 2'd3);
    read(1'b1, v); check("R9 clear", v, {12'd0, 4'b0110, 16'd0});

    // R10 clear wins over a qualifying start
    ticks(4);
    start(1'b1, 1'b0, 1'b1);               // hist 1101
    read(1'b1, v); check("R10 clear wins", v, {12'd0, 4'b1101, 16'd0});

    // R12 tick at the start is not counted
    start(1'b1, 1'b1, 1'b0);               // gap 0, hist 1011
    ticks(3);
    start(1'b1, 1'b0, 1'b0);               // gap 3, hist 0111
    read(1'b1, v); check("R12 coincident tick", v, {12'd0, 4'b0111, 16'd3});

    // R8 saturation
    wr(1'b1, 2'd0);
    @(negedge clk); lf_tick = 1'b1;
    repeat (70000) @(negedge clk);
    lf_tick = 1'b0;
    start(1'b1, 1'b0, 1'b0);               // hist 1111
    read(1'b1, v); check("R8 saturate", v, {12'd0, 4'b1111, 16'hFFFF});

    // R1 after reset again, then R7 first start
    do_reset();
    read(1'b1, v); check("R1 re-reset status", v, 32'd0);
    wr(1'b0, 2'd3);
    ticks(10);
    start(1'b1, 1'b0, 1'b0);
    read(1'b1, v); check("R7 first start", v, {12'd0, 4'b0001, 16'd0});
    ticks(6);
    start(1'b1, 1'b0, 1'b0);
    read(1'b1, v); check("R5 second start", v, {12'd0, 4'b0011, 16'd6});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule